// File: doc/BRIEF.md
# CSR Access and Privilege Unit

This block carries out the control and status register instructions of a small 64-bit core. It supports three read-modify-write kinds: swap, set bits and clear bits. Each kind comes in two forms. In the register form the source is an operand value. In the immediate form the source is a 5-bit constant that is zero-extended. Every legal access returns the value the register held before the update. The new value is committed at the next clock edge. An access that breaks a privilege or read-only rule, or that names a register the unit lacks, raises an illegal-instruction exception instead.

The unit holds the current privilege mode: user, supervisor or machine. It also holds a reduced register set:

- a scratch register
- a status register with a previous-mode bit and a two-bit floating-point state field
- a trap cause register
- an exception PC register
- a free-running cycle counter that is read-only
- a machine ISA word that is constant

The unit records traps, whether they come from illegal accesses or from environment calls. It redirects fetch to a fixed trap vector. It also performs the return-from-supervisor operation, which jumps to the saved PC and picks the new mode from the previous-mode bit. A flag tells the core when floating-point state is off, so that the core can trap floating-point stores.

The core drives one request per cycle. The destination value, the exception flag and the redirect appear in the same cycle. State changes land at the next rising clock edge.

Top module: `csr_priv_unit`

## Requirements
- R1: A swap (op_fn[1:0]=01) returns the old value and writes the source. op_fn[1:0]=00 is always illegal. op_fn[2]=1 selects the immediate form.
- R2: A set (op_fn[1:0]=10) ORs the source into the register. A clear (op_fn[1:0]=11) ANDs the register with the inverted source. Both return the pre-update value.
- R3: The immediate form uses op_src_idx zero-extended as the source. A set or clear whose source index or immediate is 0 is not a write, so it may read a read-only register.
- R4: Any write to the cycle counter (address 0xC00) is illegal: rd_we stays low and no register changes. The counter increments once per clock from 0 after reset.
- R5: An access is illegal when address bits [9:8] exceed the current mode (U=0, S=1, M=3). For example, reading status (0x100) from user mode or misa (0x301) from supervisor mode is illegal.
- R6: An address outside the implemented set is illegal. The implemented set is status 0x100, scratch 0x140, epc 0x141, cause 0x142, misa 0x301 and cycle 0xC00.
- R7: An illegal access or illegal return sets cause to 2 and epc to pc. It redirects to TRAP_VEC. It moves user or supervisor mode to supervisor, and machine mode stays machine. The previous-mode bit is set to 1 unless the trap came from user mode.
- R8: An environment call sets epc to pc and redirects to TRAP_VEC. Its cause is 8 from user mode, 9 from supervisor mode and 11 from machine mode.
- R9: A return-from-supervisor redirects to epc. It enters supervisor mode if status bit 8 is set and user mode otherwise, then clears bit 8. A return issued in user mode is illegal.
- R10: misa reads 2 in bits [63:62], bit 18 and bit 8 set, bit 20 equal to HAS_U and bit 5 equal to HAS_F. Writes to it are legal and ignored.
- R11: Status keeps only bit 8 (previous mode) and bits [14:13] (floating-point state). All other bits read zero. fs_off is high exactly when bits [14:13] are 00.
- R12: Reset enters machine mode. Scratch, status, cause and epc are cleared, so fs_off is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | CSR instruction present this cycle |
| op_fn | input | 3 | Kind in [1:0], immediate form in [2] |
| op_addr | input | 12 | CSR address |
| op_src_idx | input | 5 | Source register index, or the immediate |
| op_src_val | input | XLEN | Source register value |
| pc | input | XLEN | PC of the current instruction |
| ecall | input | 1 | Environment call this cycle |
| sret | input | 1 | Return-from-supervisor this cycle |
| rd_we | output | 1 | Destination write enable |
| rd_val | output | XLEN | Old CSR value for the destination |
| illegal_exc | output | 1 | Illegal-instruction exception |
| redirect_valid | output | 1 | Fetch redirect (trap or return) |
| redirect_pc | output | XLEN | Redirect target |
| priv_mode | output | 2 | Current privilege mode |
| fs_off | output | 1 | Floating-point state is off |

## Verification
On every cycle, the assertions check four things:

- A write to the cycle counter traps without a destination write.
- An under-privileged access is flagged.
- Each exception redirects to the trap vector.
- The mode never takes the reserved encoding, the counter steps by one, the epc captures the faulting PC, and a return with the previous-mode bit clear lands in user mode.

Some behaviour can only be shown by the bench's directed scenarios. These include the returned old values across chained swap, set and clear sequences, and the masking of status fields. They also include the cause codes per mode, the constant misa word, and the order of mode changes through traps and returns.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_t;

    typedef enum logic [1:0] {
        OP_BAD  = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } rmw_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SCRATCH,
        SEL_STATUS,
        SEL_CAUSE,
        SEL_EPC,
        SEL_MISA,
        SEL_CYCLE
    } csr_sel_t;

    typedef struct packed {
        logic     legal;
        logic     writes;
        csr_sel_t sel;
    } access_t;

    localparam logic [11:0] A_STATUS  = 12'h100;
    localparam logic [11:0] A_SCRATCH = 12'h140;
    localparam logic [11:0] A_EPC     = 12'h141;
    localparam logic [11:0] A_CAUSE   = 12'h142;
    localparam logic [11:0] A_MISA    = 12'h301;
    localparam logic [11:0] A_CYCLE   = 12'hC00;

    localparam int SPP_POS = 8;
    localparam int FS_POS  = 13;

    localparam logic [3:0] CAUSE_ILLEGAL = 4'd2;
    localparam logic [3:0] CAUSE_ECALL_U = 4'd8;

    function automatic csr_sel_t lookup(input logic [11:0] a);
        case (a)
            A_STATUS:  return SEL_STATUS;
            A_SCRATCH: return SEL_SCRATCH;
            A_EPC:     return SEL_EPC;
            A_CAUSE:   return SEL_CAUSE;
            A_MISA:    return SEL_MISA;
            A_CYCLE:   return SEL_CYCLE;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [3:0] ecall_code(input priv_t p);
        return CAUSE_ECALL_U + {2'b00, p};
    endfunction

endpackage

// File: rtl/csr_access_check.sv
module csr_access_check
    import csr_unit_pkg::*;
(
    input  logic [11:0] addr,
    input  rmw_t        kind,
    input  logic [4:0]  src_idx,
    input  priv_t       priv,
    output access_t     acc
);
    logic read_only;
    logic too_low;

    always_comb begin
        acc.sel    = lookup(addr);
        acc.writes = (kind == OP_SWAP) || (src_idx != 5'd0);
        read_only  = (addr[11:10] == 2'b11);
        too_low    = (addr[9:8] > priv);
        acc.legal  = (kind != OP_BAD) && (acc.sel != SEL_NONE)
                     && !too_low && !(read_only && acc.writes);
    end
endmodule

// File: rtl/csr_rmw.sv
module csr_rmw
    import csr_unit_pkg::*;
#(
    parameter int W = 64
) (
    input  rmw_t         kind,
    input  logic [W-1:0] old_v,
    input  logic [W-1:0] src,
    output logic [W-1:0] new_v
);
    always_comb begin
        case (kind)
            OP_SWAP: new_v = src;
            OP_SET:  new_v = old_v | src;
            OP_CLR:  new_v = old_v & ~src;
            default: new_v = old_v;
        endcase
    end
endmodule

// File: rtl/csr_state.sv
module csr_state
    import csr_unit_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter bit HAS_U = 1'b1,
    parameter bit HAS_F = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  csr_sel_t        sel,
    input  logic [XLEN-1:0] wdata,
    input  logic            trap_en,
    input  logic [3:0]      trap_code,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            sret_en,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] epc,
    output priv_t           priv,
    output logic            fs_off
);
    localparam logic [XLEN-1:0] MISA_WORD =
          (XLEN'(2) << (XLEN - 2))
        | (XLEN'(HAS_U) << 20)
        | (XLEN'(1) << 18)
        | (XLEN'(1) << 8)
        | (XLEN'(HAS_F) << 5);

    logic [XLEN-1:0] scratch_q, cause_q, epc_q, cyc_q, status_rd;
    logic            spp_q;
    logic [1:0]      fs_q;
    priv_t           priv_q;

    always_comb begin
        status_rd = '0;
        status_rd[SPP_POS] = spp_q;
        status_rd[FS_POS +: 2] = fs_q;
        case (sel)
            SEL_SCRATCH: rdata = scratch_q;
            SEL_STATUS:  rdata = status_rd;
            SEL_CAUSE:   rdata = cause_q;
            SEL_EPC:     rdata = epc_q;
            SEL_MISA:    rdata = MISA_WORD;
            SEL_CYCLE:   rdata = cyc_q;
            default:     rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            cause_q   <= '0;
            epc_q     <= '0;
            cyc_q     <= '0;
            spp_q     <= 1'b0;
            fs_q      <= 2'b00;
            priv_q    <= PRIV_M;
        end else begin
            cyc_q <= cyc_q + XLEN'(1);
            if (trap_en) begin
                cause_q <= XLEN'(trap_code);
                epc_q   <= trap_pc;
                spp_q   <= (priv_q != PRIV_U);
                priv_q  <= (priv_q == PRIV_M) ? PRIV_M : PRIV_S;
            end else if (sret_en) begin
                priv_q <= spp_q ? PRIV_S : PRIV_U;
                spp_q  <= 1'b0;
            end else if (wr_en) begin
                case (sel)
                    SEL_SCRATCH: scratch_q <= wdata;
                    SEL_CAUSE:   cause_q   <= wdata;
                    SEL_EPC:     epc_q     <= wdata;
                    SEL_STATUS: begin
                        spp_q <= wdata[SPP_POS];
                        fs_q  <= wdata[FS_POS +: 2];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign epc    = epc_q;
    assign priv   = priv_q;
    assign fs_off = (fs_q == 2'b00);

    a_r12_priv_encoding: assert property (@(posedge clk) disable iff (rst)
        priv_q != priv_t'(2'b10));

    a_r4_cycle_steps: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cyc_q == $past(cyc_q) + XLEN'(1));

    a_r7_epc_capture: assert property (@(posedge clk) disable iff (rst)
        trap_en |=> epc_q == $past(trap_pc));

    a_r9_return_user: assert property (@(posedge clk) disable iff (rst)
        (sret_en && !trap_en && !spp_q) |=> priv_q == PRIV_U);
endmodule

// File: rtl/csr_priv_unit.sv
module csr_priv_unit
    import csr_unit_pkg::*;
#(
    parameter int              XLEN     = 64,
    parameter bit              HAS_U    = 1'b1,
    parameter bit              HAS_F    = 1'b1,
    parameter logic [XLEN-1:0] TRAP_VEC = XLEN'(64'h100)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [2:0]      op_fn,
    input  logic [11:0]     op_addr,
    input  logic [4:0]      op_src_idx,
    input  logic [XLEN-1:0] op_src_val,
    input  logic [XLEN-1:0] pc,
    input  logic            ecall,
    input  logic            sret,
    output logic            rd_we,
    output logic [XLEN-1:0] rd_val,
    output logic            illegal_exc,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      priv_mode,
    output logic            fs_off
);
    localparam int IMM_PAD = XLEN - 5;

    rmw_t            kind;
    access_t         acc;
    priv_t           priv;
    logic [XLEN-1:0] src, old_v, new_v, epc;
    logic            csr_op, do_sret, do_ecall, do_write, trap;
    logic [3:0]      code;

    assign kind = rmw_t'(op_fn[1:0]);
    assign src  = op_fn[2] ? {{IMM_PAD{1'b0}}, op_src_idx} : op_src_val;

    csr_access_check u_chk (
        .addr(op_addr), .kind(kind), .src_idx(op_src_idx), .priv(priv), .acc(acc)
    );

    csr_rmw #(.W(XLEN)) u_rmw (
        .kind(kind), .old_v(old_v), .src(src), .new_v(new_v)
    );

    always_comb begin
        csr_op      = op_valid && !sret && !ecall;
        do_sret     = sret && (priv != PRIV_U);
        do_ecall    = ecall && !sret;
        illegal_exc = (sret && priv == PRIV_U) || (csr_op && !acc.legal);
        rd_we       = csr_op && acc.legal;
        do_write    = rd_we && acc.writes;
        trap        = illegal_exc || do_ecall;
        code        = illegal_exc ? CAUSE_ILLEGAL : ecall_code(priv);
        rd_val      = rd_we ? old_v : '0;
        redirect_valid = trap || do_sret;
        redirect_pc    = trap ? TRAP_VEC : epc;
    end

    csr_state #(.XLEN(XLEN), .HAS_U(HAS_U), .HAS_F(HAS_F)) u_state (
        .clk(clk), .rst(rst),
        .wr_en(do_write), .sel(acc.sel), .wdata(new_v),
        .trap_en(trap), .trap_code(code), .trap_pc(pc),
        .sret_en(do_sret),
        .rdata(old_v), .epc(epc), .priv(priv), .fs_off(fs_off)
    );

    assign priv_mode = priv;

    a_r4_cycle_write_traps: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sret && !ecall && op_addr == A_CYCLE
         && (op_fn[1:0] == 2'b01 || op_src_idx != 5'd0))
        |-> (illegal_exc && !rd_we));

    a_r5_low_priv_traps: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sret && !ecall && op_addr[9:8] > priv_mode) |-> illegal_exc);

    a_r7_trap_vector: assert property (@(posedge clk) disable iff (rst)
        illegal_exc |-> (redirect_valid && redirect_pc == TRAP_VEC));
endmodule

// File: tb/sim_csr_priv_unit.sv
`timescale 1ns/1ps
module sim_csr_priv_unit;
    localparam logic [63:0] TV = 64'h100;

    logic        clk = 1'b0, rst = 1'b1;
    logic        op_valid = 0, ecall = 0, sret = 0;
    logic [2:0]  op_fn = 0;
    logic [11:0] op_addr = 0;
    logic [4:0]  op_src_idx = 0;
    logic [63:0] op_src_val = 0, pc = 0;
    logic        rd_we, illegal_exc, redirect_valid, fs_off;
    logic [63:0] rd_val, redirect_pc;
    logic [1:0]  priv_mode;

    int total = 0, bad = 0;
    bit done = 0;
    logic        g_we, g_ill, g_rv;
    logic [63:0] g_val, g_rpc;

    always #10 clk = ~clk;

    csr_priv_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_fn(op_fn), .op_addr(op_addr),
        .op_src_idx(op_src_idx), .op_src_val(op_src_val), .pc(pc), .ecall(ecall),
        .sret(sret), .rd_we(rd_we), .rd_val(rd_val), .illegal_exc(illegal_exc),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .priv_mode(priv_mode), .fs_off(fs_off)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic capture();
        #2;
        g_we = rd_we; g_val = rd_val; g_ill = illegal_exc;
        g_rv = redirect_valid; g_rpc = redirect_pc;
        @(posedge clk);
        #1;
        op_valid = 0; ecall = 0; sret = 0;
    endtask

    task automatic op(input logic [2:0] fn, input logic [11:0] a, input logic [4:0] idx,
                      input logic [63:0] v, input logic [63:0] p);
        @(negedge clk);
        op_valid = 1; op_fn = fn; op_addr = a; op_src_idx = idx; op_src_val = v; pc = p;
        capture();
    endtask

    task automatic do_ecall(input logic [63:0] p);
        @(negedge clk);
        ecall = 1; pc = p;
        capture();
    endtask

    task automatic do_sret(input logic [63:0] p);
        @(negedge clk);
        sret = 1; pc = p;
        capture();
    endtask

    task automatic rd(input logic [11:0] a);
        op(3'b010, a, 5'd0, 64'h0, 64'h0);
    endtask

    task automatic t_reset();
        check("R12 mode after reset", priv_mode, 2'b11);
        check("R12 fs_off after reset", fs_off, 1'b1);
        rd(12'h140);
        check("R12 scratch after reset", g_val, 0);
        check("R3 zero-source set is legal read", g_we, 1'b1);
    endtask

    task automatic t_imm_sequence();
        op(3'b101, 12'h140, 5'd3, 0, 0);
        check("R1 swap-imm old value", g_val, 0);
        op(3'b111, 12'h140, 5'd1, 0, 0);
        check("R3 clear-imm returns 3", g_val, 3);
        op(3'b110, 12'h140, 5'd4, 0, 0);
        check("R3 set-imm returns 2", g_val, 2);
        op(3'b101, 12'h140, 5'd2, 0, 0);
        check("R3 swap-imm returns 6", g_val, 6);
    endtask

    task automatic t_reg_sequence();
        op(3'b001, 12'h140, 5'd10, 64'hbad1dea, 0);
        check("R1 swap returns 2", g_val, 2);
        op(3'b011, 12'h140, 5'd10, 64'h0001dea, 0);
        check("R2 clear returns old", g_val, 64'hbad1dea);
        op(3'b010, 12'h140, 5'd10, 64'h000beef, 0);
        check("R2 set returns cleared", g_val, 64'hbad0000);
        rd(12'h140);
        check("R2 final scratch", g_val, 64'hbadbeef);
        op(3'b000, 12'h140, 5'd10, 64'h1, 64'h44);
        check("R1 kind 00 illegal", g_ill, 1'b1);
    endtask

    task automatic t_cycle();
        logic [63:0] c0;
        rd(12'hC00);
        c0 = g_val;
        check("R4 cycle read legal", g_ill, 1'b0);
        rd(12'hC00);
        check("R4 cycle steps by one", g_val, c0 + 1);
        op(3'b001, 12'hC00, 5'd0, 64'hff, 64'h2000);
        check("R4 cycle write illegal", g_ill, 1'b1);
        check("R4 no rd write", g_we, 1'b0);
        check("R7 redirect to vector", g_rpc, TV);
        check("R7 machine mode kept", priv_mode, 2'b11);
        rd(12'h142);
        check("R7 cause illegal", g_val, 2);
        rd(12'h141);
        check("R7 epc captured", g_val, 64'h2000);
        op(3'b110, 12'hC00, 5'd0, 0, 0);
        check("R3 set-imm 0 on cycle legal", g_ill, 1'b0);
    endtask

    task automatic t_misa_unimpl();
        rd(12'h301);
        check("R10 misa value", g_val, 64'h8000_0000_0014_0120);
        op(3'b001, 12'h301, 5'd9, '1, 0);
        check("R10 misa write legal", g_ill, 1'b0);
        rd(12'h301);
        check("R10 misa unchanged", g_val, 64'h8000_0000_0014_0120);
        op(3'b010, 12'h7C0, 5'd0, 0, 64'h3000);
        check("R6 unimplemented illegal", g_ill, 1'b1);
    endtask

    task automatic t_status();
        op(3'b001, 12'h100, 5'd7, '1, 0);
        rd(12'h100);
        check("R11 status mask", g_val, 64'h6100);
        check("R11 fs_off low", fs_off, 1'b0);
        op(3'b011, 12'h100, 5'd7, 64'h6000, 0);
        check("R11 fs_off high", fs_off, 1'b1);
    endtask

    task automatic t_return_and_user();
        op(3'b001, 12'h141, 5'd7, 64'h8000_1000, 0);
        op(3'b011, 12'h100, 5'd7, 64'h100, 0);
        do_sret(64'h500);
        check("R9 return redirect", g_rv, 1'b1);
        check("R9 return target", g_rpc, 64'h8000_1000);
        check("R9 user mode", priv_mode, 2'b00);
        op(3'b010, 12'h100, 5'd0, 0, 64'h8000_1004);
        check("R5 user status read illegal", g_ill, 1'b1);
        check("R5 no rd write", g_we, 1'b0);
        check("R7 enters supervisor", priv_mode, 2'b01);
        rd(12'h142);
        check("R7 cause 2 from user", g_val, 2);
        rd(12'h141);
        check("R7 epc from user", g_val, 64'h8000_1004);
        rd(12'h100);
        check("R7 prev-mode bit from user", g_val, 0);
    endtask

    task automatic t_supervisor();
        op(3'b010, 12'h301, 5'd0, 0, 64'h600);
        check("R5 supervisor misa illegal", g_ill, 1'b1);
        check("R7 supervisor kept", priv_mode, 2'b01);
        do_ecall(64'h700);
        check("R8 ecall redirect", g_rpc, TV);
        rd(12'h142);
        check("R8 supervisor ecall cause", g_val, 9);
        do_sret(0);
        check("R9 return to supervisor", priv_mode, 2'b01);
        rd(12'h100);
        check("R9 prev-mode bit cleared", g_val, 0);
        do_sret(0);
        check("R9 return to user", priv_mode, 2'b00);
        do_ecall(64'h800);
        check("R8 user ecall to supervisor", priv_mode, 2'b01);
        rd(12'h142);
        check("R8 user ecall cause", g_val, 8);
        rd(12'h141);
        check("R8 ecall epc", g_val, 64'h800);
        do_sret(0);
        do_sret(64'h900);
        check("R9 return in user illegal", g_ill, 1'b1);
        rd(12'h142);
        check("R9 illegal return cause", g_val, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_imm_sequence();
        t_reg_sequence();
        t_cycle();
        t_misa_unimpl();
        t_status();
        t_return_and_user();
        t_supervisor();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule